// File: doc/BRIEF.md
# Branch Target Buffer (Direct-Mapped)

This block supplies a predicted next fetch address in the same cycle that a fetch address is presented, before the instruction has been decoded. It is a table of 2^IDX_W entries. Each entry holds a valid flag, the upper bits of a branch address used as a tag, and a predicted destination. The table is indexed straight from the fetch address. When the tag matches and the entry is valid, the stored destination is returned. Otherwise the next sequential word, fetch address plus 4, is returned.

The table changes only through a resolution port. The execute stage drives this port once it knows a branch's real outcome. Branches and jumps that resolve taken, including indirect jumps, install or refresh their entry. A branch that resolves not-taken removes its own entry if the entry is present. A write becomes visible to lookups one cycle after it is presented.

Top module: `btb_predictor`

## Requirements
- R1: While reset is asserted, all valid flags are cleared. After reset, every lookup misses until an entry is installed.
- R2: The entry index is fetch address bits [IDX_W+1:2]. The tag is bits [PC_W-1:IDX_W+2]. Address bits [1:0] take no part in selecting or matching an entry.
- R3: A resolution with `res_taken`=1 writes the entry at its index: valid set, tag from `res_pc`, destination `res_target`. From the next cycle, a lookup of that address gives `pred_hit`=1 and `pred_pc`=`res_target`.
- R4: A resolution with `res_taken`=0 whose address matches a valid entry clears that entry. From the next cycle, a lookup of that address misses.
- R5: A resolution with `res_taken`=0 whose tag differs from the entry at its index leaves that entry unchanged.
- R6: On a miss, whether from an invalid entry or a tag mismatch, `pred_hit`=0 and `pred_pc`=`fetch_pc`+4.
- R7: A lookup in the same cycle as a resolution to the same index sees the contents from before that resolution.
- R8: A taken resolution to an index that holds a different tag replaces the entry. The previous branch then misses.
- R9: Entries persist unchanged for any number of cycles without a resolution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| pred_hit | output | 1 | Valid entry with matching tag found |
| pred_pc | output | PC_W | Predicted next fetch address |
| res_valid | input | 1 | A branch resolution is presented this cycle |
| res_pc | input | PC_W | Address of the resolved branch |
| res_taken | input | 1 | Resolved direction: 1 taken, 0 not taken |
| res_target | input | PC_W | Actual destination of the taken branch |

## Verification
The bench looks up an address in the same cycle that its entry is written or cleared. A design that forwarded the write would report the new contents one cycle early. It makes two addresses alias on one index and checks each direction of resolution. A not-taken result from the other tag must not wipe the resident entry. A taken result must evict that entry, so a design that compared only the index would keep predicting for the wrong branch. It also varies the two low address bits and fills every index. An index taken from the wrong bit field then shows up as misses or as cross-hits between entries.

// File: rtl/btb_pkg.sv
package btb_pkg;
   // Instructions are word aligned; the two lowest address bits select a byte.
   localparam int unsigned WORD_OFS_W = 2;
   localparam int unsigned SEQ_STEP   = 4;
endpackage

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
   parameter int unsigned PC_W  = 32,
   parameter int unsigned IDX_W = 4,
   localparam int unsigned TAG_W = PC_W - IDX_W - btb_pkg::WORD_OFS_W
) (
   input  logic [PC_W-1:0]  addr,
   output logic [IDX_W-1:0] idx,
   output logic [TAG_W-1:0] tag
);
   localparam int unsigned IDX_LO = btb_pkg::WORD_OFS_W;
   localparam int unsigned TAG_LO = IDX_LO + IDX_W;

   always_comb begin
      idx = addr[TAG_LO-1:IDX_LO];
      tag = addr[PC_W-1:TAG_LO];
   end
endmodule

// File: rtl/btb_entry_store.sv
module btb_entry_store #(
   parameter int unsigned IDX_W = 4,
   parameter int unsigned TAG_W = 26,
   parameter int unsigned PC_W  = 32,
   localparam int unsigned ENTRIES = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_valid,
   output logic [TAG_W-1:0] rd_tag,
   output logic [PC_W-1:0]  rd_target,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_taken,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [PC_W-1:0]  wr_target
);
   logic [ENTRIES-1:0] valid_q;
   logic [TAG_W-1:0]   tag_q [ENTRIES];
   logic [PC_W-1:0]    tgt_q [ENTRIES];
   logic               wr_match;

   // A not-taken result may only remove the entry that belongs to it.
   always_comb wr_match = valid_q[wr_idx] && (tag_q[wr_idx] == wr_tag);

   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      logic sel;
      always_comb sel = wr_en && (wr_idx == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q[e] <= 1'b0;
         end else if (sel) begin
            if (wr_taken)      valid_q[e] <= 1'b1;
            else if (wr_match) valid_q[e] <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (sel && wr_taken) begin
            tag_q[e] <= wr_tag;
            tgt_q[e] <= wr_target;
         end
      end
   end

   always_comb begin
      rd_valid  = valid_q[rd_idx];
      rd_tag    = tag_q[rd_idx];
      rd_target = tgt_q[rd_idx];
   end

   // R9
   valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && !$past(wr_en) |-> $stable(valid_q));

   // R4
   no_alloc_on_nt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(wr_en && !wr_taken)
      |-> $countones(valid_q) <= $past($countones(valid_q)));
endmodule

// File: rtl/btb_lookup.sv
module btb_lookup #(
   parameter int unsigned PC_W  = 32,
   parameter int unsigned TAG_W = 26
) (
   input  logic [PC_W-1:0]  cur_pc,
   input  logic [TAG_W-1:0] cur_tag,
   input  logic             ent_valid,
   input  logic [TAG_W-1:0] ent_tag,
   input  logic [PC_W-1:0]  ent_target,
   output logic             hit,
   output logic [PC_W-1:0]  next_pc
);
   logic [PC_W-1:0] seq_pc;

   always_comb begin
      seq_pc  = cur_pc + PC_W'(btb_pkg::SEQ_STEP);
      hit     = ent_valid && (ent_tag == cur_tag);
      next_pc = hit ? ent_target : seq_pc;
   end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor #(
   parameter int unsigned PC_W  = 32,
   parameter int unsigned IDX_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] fetch_pc,
   output logic            pred_hit,
   output logic [PC_W-1:0] pred_pc,
   input  logic            res_valid,
   input  logic [PC_W-1:0] res_pc,
   input  logic            res_taken,
   input  logic [PC_W-1:0] res_target
);
   localparam int unsigned TAG_W = PC_W - IDX_W - btb_pkg::WORD_OFS_W;

   if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
      $error("btb_predictor: IDX_W must lie in 1..12");
   end
   if (PC_W < IDX_W + btb_pkg::WORD_OFS_W + 1) begin : g_bad_pc
      $error("btb_predictor: PC_W too narrow for a tag");
   end

   logic [IDX_W-1:0] f_idx, r_idx;
   logic [TAG_W-1:0] f_tag, r_tag, e_tag;
   logic             e_valid;
   logic [PC_W-1:0]  e_target;

   btb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_split_fetch (
      .addr(fetch_pc), .idx(f_idx), .tag(f_tag));

   btb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_split_res (
      .addr(res_pc), .idx(r_idx), .tag(r_tag));

   btb_entry_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(f_idx), .rd_valid(e_valid), .rd_tag(e_tag), .rd_target(e_target),
      .wr_en(res_valid), .wr_idx(r_idx), .wr_taken(res_taken),
      .wr_tag(r_tag), .wr_target(res_target));

   btb_lookup #(.PC_W(PC_W), .TAG_W(TAG_W)) u_lookup (
      .cur_pc(fetch_pc), .cur_tag(f_tag),
      .ent_valid(e_valid), .ent_tag(e_tag), .ent_target(e_target),
      .hit(pred_hit), .next_pc(pred_pc));

   // R3
   taken_installs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(res_valid && res_taken) && (fetch_pc == $past(res_pc))
      |-> pred_hit && (pred_pc == $past(res_target)));

   // R4
   nt_removes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(res_valid && !res_taken) && (fetch_pc == $past(res_pc))
      |-> !pred_hit);
endmodule

// File: tb/btb_predictor_tb.sv
module btb_predictor_tb;
   localparam int unsigned PC_W  = 32;
   localparam int unsigned IDX_W = 4;
   localparam int unsigned NENT  = 1 << IDX_W;
   localparam int unsigned TAG_W = PC_W - IDX_W - 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [PC_W-1:0] fetch_pc = '0;
   logic            pred_hit;
   logic [PC_W-1:0] pred_pc;
   logic            res_valid = 1'b0;
   logic [PC_W-1:0] res_pc = '0;
   logic            res_taken = 1'b0;
   logic [PC_W-1:0] res_target = '0;

   always #2 clk = ~clk;

   btb_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
      .pred_hit(pred_hit), .pred_pc(pred_pc),
      .res_valid(res_valid), .res_pc(res_pc),
      .res_taken(res_taken), .res_target(res_target));

   typedef struct {
      logic            hit;
      logic [PC_W-1:0] npc;
      string           req;
   } exp_t;

   exp_t            sb_q[$];
   int              n_chk = 0;
   int              n_fail = 0;
   bit              done = 1'b0;

   // Bench model of the table, built from the requirement text.
   logic             m_v   [NENT];
   logic [TAG_W-1:0] m_tag [NENT];
   logic [PC_W-1:0]  m_tgt [NENT];

   function automatic int unsigned idx_of(logic [PC_W-1:0] a);
      return int'(a[IDX_W+1:2]);
   endfunction
   function automatic logic [TAG_W-1:0] tag_of(logic [PC_W-1:0] a);
      return a[PC_W-1:IDX_W+2];
   endfunction

   task automatic model_clear();
      for (int i = 0; i < NENT; i++) m_v[i] = 1'b0;
   endtask

   // Driver: present one cycle of stimulus, queue the expected prediction,
   // then apply the resolution to the model (it takes effect next cycle).
   task automatic step(input logic [PC_W-1:0] fpc, input logic rv,
                       input logic [PC_W-1:0] rpc, input logic rt,
                       input logic [PC_W-1:0] rtgt, input string req);
      exp_t e;
      int unsigned fi, ri;
      @(negedge clk);
      fetch_pc = fpc; res_valid = rv; res_pc = rpc;
      res_taken = rt; res_target = rtgt;
      fi = idx_of(fpc);
      e.hit = m_v[fi] && (m_tag[fi] == tag_of(fpc));
      e.npc = e.hit ? m_tgt[fi] : fpc + 32'd4;
      e.req = req;
      sb_q.push_back(e);
      if (rv) begin
         ri = idx_of(rpc);
         if (rt) begin
            m_v[ri] = 1'b1; m_tag[ri] = tag_of(rpc); m_tgt[ri] = rtgt;
         end else if (m_v[ri] && m_tag[ri] == tag_of(rpc)) begin
            m_v[ri] = 1'b0;
         end
      end
   endtask

   task automatic look(input logic [PC_W-1:0] fpc, input string req);
      step(fpc, 1'b0, '0, 1'b0, '0, req);
   endtask

   task automatic do_reset();
      @(negedge clk);
      res_valid = 1'b0;
      rst_n = 1'b0;
      model_clear();
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Monitor: pops each expected item one unit after it is driven.
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         #1;
         if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            n_chk++;
            if (pred_hit !== e.hit || pred_pc !== e.npc) begin
               n_fail++;
               $display("FAIL %s: hit=%0b pc=%h expected hit=%0b pc=%h",
                        e.req, pred_hit, pred_pc, e.hit, e.npc);
            end
         end
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run hung, actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   localparam logic [PC_W-1:0] PA = 32'h0000_1000; // index 0
   localparam logic [PC_W-1:0] PB = 32'h0000_2000; // index 0, other tag
   localparam logic [PC_W-1:0] PC_ = 32'h0000_1004; // index 1

   initial begin
      model_clear();
      do_reset();
      look(PA,  "R1 reset miss");
      look(PC_, "R1 reset miss");
      // R7: same-cycle install is not visible yet
      step(PA, 1'b1, PA, 1'b1, 32'h0000_4000, "R7 old contents on install");
      look(PA, "R3 taken install hits");
      look(PA + 32'd2, "R2 low bits ignored");
      // R5 / R6: alias with different tag
      step(PB, 1'b1, PB, 1'b0, '0, "R6 tag mismatch miss");
      look(PA, "R5 foreign not-taken keeps entry");
      // R8: alias taken replaces
      step(PC_, 1'b1, PB, 1'b1, 32'h0000_8000, "R6 invalid entry miss");
      look(PA, "R8 evicted branch misses");
      look(PB, "R8 replacing branch hits");
      // R7 / R4: clear while looking up
      step(PB, 1'b1, PB, 1'b0, '0, "R7 old contents on clear");
      look(PB, "R4 not-taken clears entry");
      // R9: persistence
      step(PA, 1'b1, PC_, 1'b1, 32'h0000_00C0, "R6 miss after clear");
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         res_valid = 1'b0;
      end
      look(PC_, "R9 entry persists");
      // R2: fill every index, then read each back
      for (int i = 0; i < NENT; i++) begin
         step(32'h0003_0000 + 32'(i * 4), 1'b1, 32'h0005_0000 + 32'(i * 4),
              1'b1, 32'h0009_0000 + 32'(i * 16), "R2 fill");
      end
      for (int i = 0; i < NENT; i++) begin
         look(32'h0005_0000 + 32'(i * 4) + 32'(i % 4), "R2 index field");
      end
      // R1: reset wipes a full table
      do_reset();
      for (int i = 0; i < NENT; i++) begin
         look(32'h0005_0000 + 32'(i * 4), "R1 cleared by reset");
      end
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule